// File: doc/BRIEF.md
# Port Transfer Status and Interrupt Register

This block holds the eight-bit control and status byte for one parallel data port on a bus-attached digital I/O card. It records when the port's data register is ready for the host and whether a transfer took place. It keeps the handshake-enable setting. It also latches interrupt causes from three sources: completed transfers, host-forced requests, and edges on an external peripheral interrupt line. All of these are merged onto one interrupt request output.

The host writes the byte through a simple write strobe. It reads the byte at any time from a combinational read-data bus. Other parts of the card are represented by input strobes and levels: port selection, the handshake machine, the card-level registers and the bus protocol. These are a pulse when the port becomes ready, a pulse when the host reads the port data register, and the mode, enable and force-control bits kept elsewhere on the card.

The peripheral interrupt bit serves as both enable and pending status. Writing 1 arms it. Writing 0 disarms it and drops any pending event. Software re-arms after an event by writing 0 and then 1. The line is synchronised before edge detection, and the active edge direction comes from a polarity input.

Top module: `ptx_stat_reg`

## Requirements
- R1: After synchronous reset, `rdata` reads 0x00, `hs_enable` is 0 and `irq` is 0.
- R2: A one-cycle `xfer_rdy` pulse sets `rdata[0]` (ready) and `rdata[5]` (transfer flag) at the next clock edge. A `dreg_rd` pulse clears both at the next edge. If both strobes are high in the same cycle, the set wins.
- R3: A host write stores `host_wdata[1]` as the handshake enable, which reads back in `rdata[1]` and drives `hs_enable`.
- R4: Bits 2 to 4 of `rdata` always read 0. Host writes have no effect on bits 0, 5 and 6.
- R5: `rdata[6]` (forced flag) becomes 1 at the edge after `force_ctl`, `port_irq_en` and `card_force` are all 1. It returns to 0 at the edge after any of the three drops.
- R6: The transfer flag drives `irq` only while `irq_mode_sel` (interrupt-driven mode) and `irq_en` are both 1.
- R7: `periph_line` passes through SYNC_STAGES (default 2) flip-flops before edge detection. The active edge is rising when `edge_pol` is 0 and falling when it is 1. With the defaults, an active edge shows in `rdata[7]` at the third clock edge after the line changes. An edge in the other direction is never latched.
- R8: Edges on `periph_line` are not latched while the peripheral enable (last written `host_wdata[7]`) is 0. Turning the enable on later does not latch an edge that occurred earlier.
- R9: Writing `host_wdata[7]`=0 clears the pending peripheral flag and disables capture. Writing 1 while the flag is pending leaves it pending. The sequence write 0, then write 1 clears the flag and re-arms capture.
- R10: `irq` is the OR of the masked transfer term, the forced flag and the pending peripheral flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the register |
| host_wdata | input | 8 | Host write data |
| rdata | output | 8 | Register read value |
| dreg_rd | input | 1 | Pulse: host read the port data register |
| xfer_rdy | input | 1 | Pulse: port data register became ready |
| irq_mode_sel | input | 1 | Port is in interrupt-driven transfer mode |
| irq_en | input | 1 | Transfer interrupt enable |
| force_ctl | input | 1 | Forced-interrupt control bit |
| port_irq_en | input | 1 | Port interrupt enable bit |
| card_force | input | 1 | Card-level forced-interrupt bit |
| periph_line | input | 1 | Asynchronous peripheral interrupt line |
| edge_pol | input | 1 | 0 = rising edge active, 1 = falling edge active |
| hs_enable | output | 1 | Handshake enable to the port handshake logic |
| irq | output | 1 | Interrupt request |

## Verification
The peripheral line is driven with rising and falling transitions under both polarity settings. This shows that only the selected direction is latched. Checks at the second and third edges after a change confirm the synchroniser latency. The enable is toggled around edges to show that capture depends on it, and a re-arm sequence is run against a plain rewrite of 1. The transfer strobes are applied alone and together to expose the set-over-clear priority. The three force inputs are applied in partial and full combinations. The mode and enable inputs are swept to show which combinations let the transfer flag reach the interrupt output.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int REG_W      = 8;
    localparam int BIT_READY  = 0;
    localparam int BIT_HS     = 1;
    localparam int BIT_XFER   = 5;
    localparam int BIT_FORCE  = 6;
    localparam int BIT_PERIPH = 7;

    typedef struct packed {
        logic periph_pend;
        logic force_flag;
        logic xfer_flag;
        logic hs_en;
        logic ready;
    } ptx_stat_t;

    function automatic logic [REG_W-1:0] pack_stat(input ptx_stat_t s);
        logic [REG_W-1:0] r;
        r             = '0;
        r[BIT_READY]  = s.ready;
        r[BIT_HS]     = s.hs_en;
        r[BIT_XFER]   = s.xfer_flag;
        r[BIT_FORCE]  = s.force_flag;
        r[BIT_PERIPH] = s.periph_pend;
        return r;
    endfunction

endpackage

// File: rtl/ptx_edge_sync.sv
module ptx_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic fall_sel,
    output logic edge_evt
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   synced;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign synced = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= synced;
    end

    always_comb begin
        if (fall_sel) edge_evt = prev & ~synced;
        else          edge_evt = ~prev & synced;
    end

    // R7: an event always coincides with a change of the synchronised level
    p_edge_is_change_r7: assert property (@(posedge clk) disable iff (rst)
        edge_evt |-> (synced != prev));

endmodule

// File: rtl/ptx_flags.sv
module ptx_flags (
    input  logic clk,
    input  logic rst,
    input  logic xfer_rdy,
    input  logic dreg_rd,
    input  logic force_ctl,
    input  logic port_irq_en,
    input  logic card_force,
    output logic ready,
    output logic xfer_flag,
    output logic force_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready     <= 1'b0;
            xfer_flag <= 1'b0;
        end else if (xfer_rdy) begin
            ready     <= 1'b1;
            xfer_flag <= 1'b1;
        end else if (dreg_rd) begin
            ready     <= 1'b0;
            xfer_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) force_flag <= 1'b0;
        else     force_flag <= force_ctl & port_irq_en & card_force;
    end

    p_set_wins_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_rdy |=> (ready && xfer_flag));

    p_clear_on_read_r2: assert property (@(posedge clk) disable iff (rst)
        (dreg_rd && !xfer_rdy) |=> (!ready && !xfer_flag));

    p_force_needs_all_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(force_flag) |-> ($past(force_ctl) && $past(port_irq_en) && $past(card_force)));

endmodule

// File: rtl/ptx_periph.sv
module ptx_periph (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic edge_evt,
    output logic en,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (wr_en) en <= wr_bit;
            if (wr_en && !wr_bit)    pend <= 1'b0;
            else if (en && edge_evt) pend <= 1'b1;
        end
    end

    p_pend_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> ($past(en) && $past(edge_evt)));

    p_write0_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_bit) |=> (!pend && !en));

    p_write1_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_bit && pend) |=> pend);

endmodule

// File: rtl/ptx_stat_reg.sv
module ptx_stat_reg
    import ptx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             dreg_rd,
    input  logic             xfer_rdy,
    input  logic             irq_mode_sel,
    input  logic             irq_en,
    input  logic             force_ctl,
    input  logic             port_irq_en,
    input  logic             card_force,
    input  logic             periph_line,
    input  logic             edge_pol,
    output logic             hs_enable,
    output logic             irq
);
    ptx_stat_t st;
    logic      hs_q;
    logic      edge_evt;
    logic      periph_en;
    logic      xfer_term;

    always_ff @(posedge clk) begin
        if (rst)          hs_q <= 1'b0;
        else if (host_wr) hs_q <= host_wdata[BIT_HS];
    end

    ptx_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .xfer_rdy    (xfer_rdy),
        .dreg_rd     (dreg_rd),
        .force_ctl   (force_ctl),
        .port_irq_en (port_irq_en),
        .card_force  (card_force),
        .ready       (st.ready),
        .xfer_flag   (st.xfer_flag),
        .force_flag  (st.force_flag)
    );

    ptx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_in  (periph_line),
        .fall_sel (edge_pol),
        .edge_evt (edge_evt)
    );

    ptx_periph u_periph (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_wr),
        .wr_bit   (host_wdata[BIT_PERIPH]),
        .edge_evt (edge_evt),
        .en       (periph_en),
        .pend     (st.periph_pend)
    );

    assign st.hs_en  = hs_q;
    assign rdata     = pack_stat(st);
    assign hs_enable = hs_q;
    assign xfer_term = st.xfer_flag & irq_mode_sel & irq_en;
    assign irq       = xfer_term | st.force_flag | st.periph_pend;

    p_hs_write_r3: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (hs_enable == $past(host_wdata[BIT_HS])));

    p_unused_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rdata[4:2] == 3'b000);

    p_irq_sources_r10: assert property (@(posedge clk) disable iff (rst)
        (rdata[BIT_PERIPH] || rdata[BIT_FORCE]) |-> irq);

    p_masked_xfer_r6: assert property (@(posedge clk) disable iff (rst)
        (!rdata[BIT_PERIPH] && !rdata[BIT_FORCE] && !(irq_mode_sel && irq_en)) |-> !irq);

endmodule

// File: tb/ptx_stat_reg_bench.sv
module ptx_stat_reg_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr;
    logic [7:0] host_wdata;
    logic [7:0] rdata;
    logic       dreg_rd, xfer_rdy, irq_mode_sel, irq_en;
    logic       force_ctl, port_irq_en, card_force;
    logic       periph_line, edge_pol;
    logic       hs_enable, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ptx_stat_reg u_ptx_stat_reg (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .rdata(rdata), .dreg_rd(dreg_rd), .xfer_rdy(xfer_rdy),
        .irq_mode_sel(irq_mode_sel), .irq_en(irq_en), .force_ctl(force_ctl),
        .port_irq_en(port_irq_en), .card_force(card_force),
        .periph_line(periph_line), .edge_pol(edge_pol),
        .hs_enable(hs_enable), .irq(irq)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        host_wr = 1'b1; host_wdata = v;
        tick();
        host_wr = 1'b0; host_wdata = 8'h00;
    endtask

    task automatic t_reset;
        chk("R1 rdata after reset", rdata, 8'h00);
        chk("R1 hs_enable after reset", {7'd0, hs_enable}, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_transfer;
        xfer_rdy = 1'b1; tick(); xfer_rdy = 1'b0;
        chk("R2 ready and transfer set", rdata & 8'h21, 8'h21);
        chk("R6 irq masked, mode off", {7'd0, irq}, 8'h00);
        irq_mode_sel = 1'b1; #1;
        chk("R6 irq masked, enable off", {7'd0, irq}, 8'h00);
        irq_mode_sel = 1'b0; irq_en = 1'b1; #1;
        chk("R6 irq masked, mode off enable on", {7'd0, irq}, 8'h00);
        irq_mode_sel = 1'b1; #1;
        chk("R6 irq with mode and enable", {7'd0, irq}, 8'h01);
        dreg_rd = 1'b1; tick(); dreg_rd = 1'b0;
        chk("R2 cleared by data read", rdata & 8'h21, 8'h00);
        chk("R10 irq drops after read", {7'd0, irq}, 8'h00);
        xfer_rdy = 1'b1; dreg_rd = 1'b1; tick(); xfer_rdy = 1'b0; dreg_rd = 1'b0;
        chk("R2 set wins over clear", rdata & 8'h21, 8'h21);
        dreg_rd = 1'b1; tick(); dreg_rd = 1'b0;
        irq_mode_sel = 1'b0; irq_en = 1'b0;
    endtask

    task automatic t_write_fields;
        host_write(8'h7F);
        chk("R3 handshake bit reads 1", rdata & 8'h02, 8'h02);
        chk("R3 hs_enable output", {7'd0, hs_enable}, 8'h01);
        chk("R4 write ignored on bits 0 and 2-6", rdata & 8'h7D, 8'h00);
        host_write(8'h00);
        chk("R3 handshake cleared", {7'd0, hs_enable}, 8'h00);
        chk("R3 rdata zero after clear", rdata, 8'h00);
    endtask

    task automatic t_force;
        force_ctl = 1'b1; port_irq_en = 1'b1; card_force = 1'b0; tick();
        chk("R5 two of three gives no flag", rdata & 8'h40, 8'h00);
        force_ctl = 1'b0; card_force = 1'b1; tick();
        chk("R5 other two of three gives no flag", rdata & 8'h40, 8'h00);
        force_ctl = 1'b1; #1;
        chk("R5 flag not yet set before edge", rdata & 8'h40, 8'h00);
        tick();
        chk("R5 all three sets flag", rdata & 8'h40, 8'h40);
        chk("R10 forced flag raises irq", {7'd0, irq}, 8'h01);
        port_irq_en = 1'b0; tick();
        chk("R5 flag drops with input", rdata & 8'h40, 8'h00);
        force_ctl = 1'b0; card_force = 1'b0;
    endtask

    task automatic t_periph;
        edge_pol = 1'b0;
        host_write(8'h80);
        chk("R9 enable write keeps flag clear", rdata & 8'h80, 8'h00);
        periph_line = 1'b1;
        tick(2);
        chk("R7 not visible after two edges", rdata & 8'h80, 8'h00);
        tick();
        chk("R7 rising edge latched on third edge", rdata & 8'h80, 8'h80);
        chk("R10 peripheral raises irq", {7'd0, irq}, 8'h01);
        host_write(8'h80);
        chk("R9 rewrite of 1 keeps pending", rdata & 8'h80, 8'h80);
        host_write(8'h00);
        chk("R9 write 0 clears pending", rdata & 8'h80, 8'h00);
        chk("R9 irq drops after clear", {7'd0, irq}, 8'h00);
        host_write(8'h80);
        periph_line = 1'b0;
        tick(4);
        chk("R7 falling ignored under rising polarity", rdata & 8'h80, 8'h00);
        edge_pol = 1'b1;
        periph_line = 1'b1;
        tick(4);
        chk("R7 rising ignored under falling polarity", rdata & 8'h80, 8'h00);
        periph_line = 1'b0;
        tick(2);
        chk("R7 falling not visible after two edges", rdata & 8'h80, 8'h00);
        tick();
        chk("R7 falling edge latched", rdata & 8'h80, 8'h80);
        host_write(8'h00);
        host_write(8'h80);
        chk("R9 re-armed flag clear", rdata & 8'h80, 8'h00);
        periph_line = 1'b1; tick(4);
        periph_line = 1'b0; tick(4);
        chk("R9 re-armed capture works", rdata & 8'h80, 8'h80);
        host_write(8'h00);
    endtask

    task automatic t_disabled;
        edge_pol = 1'b0;
        periph_line = 1'b1;
        tick(4);
        chk("R8 edge ignored while disabled", rdata & 8'h80, 8'h00);
        host_write(8'h80);
        tick(4);
        chk("R8 no late capture after enable", rdata & 8'h80, 8'h00);
        chk("R8 irq quiet", {7'd0, irq}, 8'h00);
        host_write(8'h00);
        periph_line = 1'b0;
        tick(4);
    endtask

    initial begin
        rst = 1'b1; host_wr = 1'b0; host_wdata = 8'h00;
        dreg_rd = 1'b0; xfer_rdy = 1'b0; irq_mode_sel = 1'b0; irq_en = 1'b0;
        force_ctl = 1'b0; port_irq_en = 1'b0; card_force = 1'b0;
        periph_line = 1'b0; edge_pol = 1'b0;
        tick(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_transfer();
        t_write_fields();
        t_force();
        t_periph();
        t_disabled();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule